// File: doc/BRIEF.md
# TLB Range Invalidation Engine

This block owns a small, fully associative TLB of stage-2-only translations and removes entries from it in response to a single 64-bit range-invalidate operand. The operand packs several fields: a security-space select, a translation granule code, a scale exponent, a page count, a level hint and a base address. The block decodes these fields, works out the exclusive upper bound of the address window, and then sweeps the TLB one entry per cycle in ascending index order. Any entry whose VMID, IPA space, granule, level and page address all fit the request has its valid bit cleared.

A request is taken when `req_i` and `ready_o` are both high. `ready_o` stays low until the sweep ends, and the end is marked by a one-cycle `done_o` pulse. The block also raises `unpred_o` when the base address is not aligned to the table level named by the hint. A fill port writes entries, and this port keeps working during a sweep. A registered read port lets the surrounding logic or a test inspect any entry.

Top module: `tlbri_engine`

## Requirements
- R1: Operand bit 63 is the space select, bits 47:46 the granule, 45:44 the scale, 43:39 the count, 38:37 the level hint, 36:0 the base field. Bits 62:48 have no effect on any outcome.
- R2: Granule code 01 selects 4K, 10 selects 16K and 11 selects 64K. Code 00 clears no entry.
- R3: The base field is placed at IPA bit 12 (4K), bit 14 (16K) or bit 16 (64K), and the lower bits are zero.
- R4: An entry address A is in range when base <= A < base + (count+1) * 2^(5*scale+1) * granule bytes. The upper bound is computed one bit wider than the 53-bit IPA, so it never wraps.
- R5: Hint 00 accepts any entry level, and hints 01, 10 and 11 accept only levels 1, 2 and 3. With the 16K granule, hint 01 behaves as 00.
- R6: An entry is cleared only if its VMID equals the VMID captured with the request and its granule code equals the operand's granule code.
- R7: From non-secure state (`cur_secure_i`=0) only entries with space bit 1 (non-secure) are targeted, whatever bit 63 holds. From secure state, bit 63 = 0 targets space 0 and bit 63 = 1 targets space 1.
- R8: `unpred_o` is 1 for these cases and 0 otherwise. 4K with hint 01 and IPA[29:12] nonzero. 4K with hint 10 and IPA[20:12] nonzero. 16K with hint 10 and IPA[24:14] nonzero. 64K with hint 01 and IPA[41:16] nonzero. 64K with hint 10 and IPA[28:16] nonzero. It is valid while `done_o` is high.
- R9: A request taken on clock edge E yields `done_o` high for exactly one cycle after edge E+DEPTH. `ready_o` is low between the two, and a request held during that time is ignored.
- R10: A fill to the entry being examined in the same cycle takes precedence, so that entry ends with the filled contents.
- R11: The read port returns the valid bit and payload of entry `rd_idx_i` one clock after the index is presented. After reset, every entry reads as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Invalidate request |
| op_i | input | 64 | Range-invalidate operand |
| cur_vmid_i | input | VMID_W | Current VMID, captured at request |
| cur_secure_i | input | 1 | Requester is in secure state |
| ready_o | output | 1 | Engine can take a request |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| unpred_o | output | 1 | Base misaligned for level hint |
| fill_en_i | input | 1 | Write one TLB entry |
| fill_idx_i | input | IDX_W | Entry index to write |
| fill_valid_i | input | 1 | Valid bit written |
| fill_vmid_i | input | VMID_W | VMID written |
| fill_ns_i | input | 1 | Space bit written (1 = non-secure) |
| fill_gran_i | input | 2 | Granule code written |
| fill_lvl_i | input | 2 | Table level written |
| fill_addr_i | input | 53 | Page-aligned IPA written |
| rd_idx_i | input | IDX_W | Entry index to read |
| rd_valid_o | output | 1 | Valid bit of read entry |
| rd_vmid_o | output | VMID_W | VMID of read entry |
| rd_ns_o | output | 1 | Space bit of read entry |
| rd_gran_o | output | 2 | Granule code of read entry |
| rd_lvl_o | output | 2 | Level of read entry |
| rd_addr_o | output | 53 | IPA of read entry |

## Verification
The sweep's clear and a fill from the outside can target the same entry on the same clock edge. The bench sets this up by counting edges from acceptance and driving a fill to index k just before the edge on which the sweep examines entry k. The filled entry is built so that it would itself match the range. After `done_o`, reading that index back must show it valid with the new address, which proves that the fill took precedence over the clear.

// File: rtl/tlbri_pkg.sv
package tlbri_pkg;

  localparam int IPA_W = 53;
  localparam int END_W = IPA_W + 1;

  typedef enum logic [1:0] {
    GR_RSVD = 2'b00,
    GR_4K   = 2'b01,
    GR_16K  = 2'b10,
    GR_64K  = 2'b11
  } gran_e;

  typedef enum logic [1:0] {
    LH_ANY = 2'b00,
    LH_L1  = 2'b01,
    LH_L2  = 2'b10,
    LH_L3  = 2'b11
  } lvl_hint_e;

  typedef struct packed {
    logic              ns;
    gran_e             gran;
    lvl_hint_e         hint;
    logic [IPA_W-1:0]  lo;
    logic [END_W-1:0]  hi;
  } range_cmd_t;

endpackage

// File: rtl/tlbri_decode.sv
module tlbri_decode
  import tlbri_pkg::*;
#(
  parameter int OP_W = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            secure_i,
  output range_cmd_t      cmd_o,
  output logic            unpred_o
);

  localparam int SPACE_BIT = 63;
  localparam int GRAN_LO   = 46;
  localparam int SCALE_LO  = 44;
  localparam int CNT_LO    = 39;
  localparam int HINT_LO   = 37;
  localparam int BASE_W    = 37;
  localparam int RSV_HI    = 62;
  localparam int RSV_LO    = 48;

  gran_e            gran;
  lvl_hint_e        hint_raw;
  logic [4:0]       gshift;
  logic [1:0]       scale;
  logic [5:0]       cnt_p1;
  logic [5:0]       exp_amt;
  logic [END_W-1:0] base_ext;
  logic [END_W-1:0] span;
  logic [IPA_W-1:0] lo;
  logic             unused_rsv;

  assign unused_rsv = ^op_i[RSV_HI:RSV_LO];

  assign gran     = gran_e'(op_i[GRAN_LO +: 2]);
  assign hint_raw = lvl_hint_e'(op_i[HINT_LO +: 2]);
  assign scale    = op_i[SCALE_LO +: 2];
  assign cnt_p1   = {1'b0, op_i[CNT_LO +: 5]} + 6'd1;

  always_comb begin
    case (gran)
      GR_16K:  gshift = 5'd14;
      GR_64K:  gshift = 5'd16;
      default: gshift = 5'd12;
    endcase
  end

  assign exp_amt  = ({4'b0, scale} << 2) + {4'b0, scale} + 6'd1 + {1'b0, gshift};
  assign base_ext = {{(END_W-BASE_W){1'b0}}, op_i[BASE_W-1:0]} << gshift;
  assign span     = {{(END_W-6){1'b0}}, cnt_p1} << exp_amt;
  assign lo       = base_ext[IPA_W-1:0];

  always_comb begin
    cmd_o.gran = gran;
    cmd_o.lo   = lo;
    cmd_o.hi   = base_ext + span;
    cmd_o.ns   = secure_i ? op_i[SPACE_BIT] : 1'b1;
    if (gran == GR_16K && hint_raw == LH_L1) cmd_o.hint = LH_ANY;
    else                                     cmd_o.hint = hint_raw;
  end

  always_comb begin
    unpred_o = 1'b0;
    case (gran)
      GR_4K: begin
        if (hint_raw == LH_L1) unpred_o = |lo[29:12];
        if (hint_raw == LH_L2) unpred_o = |lo[20:12];
      end
      GR_16K: begin
        if (hint_raw == LH_L2) unpred_o = |lo[24:14];
      end
      GR_64K: begin
        if (hint_raw == LH_L1) unpred_o = |lo[41:16];
        if (hint_raw == LH_L2) unpred_o = |lo[28:16];
      end
      default: unpred_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tlbri_match.sv
module tlbri_match
  import tlbri_pkg::*;
#(
  parameter int VMID_W = 16
) (
  input  range_cmd_t        cmd_i,
  input  logic [VMID_W-1:0] vmid_i,
  input  logic              e_valid_i,
  input  logic [VMID_W-1:0] e_vmid_i,
  input  logic              e_ns_i,
  input  logic [1:0]        e_gran_i,
  input  logic [1:0]        e_lvl_i,
  input  logic [IPA_W-1:0]  e_addr_i,
  output logic              hit_o
);

  logic gran_ok;
  logic lvl_ok;
  logic addr_ok;
  logic id_ok;

  assign gran_ok = (cmd_i.gran != GR_RSVD) && (e_gran_i == cmd_i.gran);
  assign lvl_ok  = (cmd_i.hint == LH_ANY) || (e_lvl_i == cmd_i.hint);
  assign addr_ok = (e_addr_i >= cmd_i.lo) && ({1'b0, e_addr_i} < cmd_i.hi);
  assign id_ok   = (e_vmid_i == vmid_i) && (e_ns_i == cmd_i.ns);
  assign hit_o   = e_valid_i && gran_ok && lvl_ok && addr_ok && id_ok;

endmodule

// File: rtl/tlbri_store.sv
module tlbri_store
  import tlbri_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VMID_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [VMID_W-1:0] wr_vmid_i,
  input  logic              wr_ns_i,
  input  logic [1:0]        wr_gran_i,
  input  logic [1:0]        wr_lvl_i,
  input  logic [IPA_W-1:0]  wr_addr_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [IDX_W-1:0]  scan_idx_i,
  output logic              scan_valid_o,
  output logic [VMID_W-1:0] scan_vmid_o,
  output logic              scan_ns_o,
  output logic [1:0]        scan_gran_o,
  output logic [1:0]        scan_lvl_o,
  output logic [IPA_W-1:0]  scan_addr_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [VMID_W-1:0] rd_vmid_o,
  output logic              rd_ns_o,
  output logic [1:0]        rd_gran_o,
  output logic [1:0]        rd_lvl_o,
  output logic [IPA_W-1:0]  rd_addr_o
);

  localparam int PAY_W = VMID_W + 1 + 2 + 2 + IPA_W;

  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PAY_W-1:0] wr_word;
  logic [PAY_W-1:0] scan_word;
  logic [PAY_W-1:0] rd_word_q;
  logic             rd_valid_q;

  assign wr_word = {wr_vmid_i, wr_ns_i, wr_gran_i, wr_lvl_i, wr_addr_i};

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pay_mem[wr_idx_i] <= wr_word;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    always_ff @(posedge clk_i) begin
      if (rst_i)                                          valid_q[g] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))          valid_q[g] <= wr_valid_i;
      else if (clr_en_i && clr_idx_i == IDX_W'(g))        valid_q[g] <= 1'b0;
    end
  end

  assign scan_word    = pay_mem[scan_idx_i];
  assign scan_valid_o = valid_q[scan_idx_i];
  assign {scan_vmid_o, scan_ns_o, scan_gran_o, scan_lvl_o, scan_addr_o} = scan_word;

  always_ff @(posedge clk_i) begin
    rd_word_q <= pay_mem[rd_idx_i];
    if (rst_i) rd_valid_q <= 1'b0;
    else       rd_valid_q <= valid_q[rd_idx_i];
  end

  assign rd_valid_o = rd_valid_q;
  assign {rd_vmid_o, rd_ns_o, rd_gran_o, rd_lvl_o, rd_addr_o} = rd_word_q;

  AST_FILL_WINS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_valid_i && clr_en_i && wr_idx_i == clr_idx_i) |=> valid_q[$past(clr_idx_i)]); // R10

  AST_VALID_RISE_FROM_FILL: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(valid_q & ~$past(valid_q))) |-> $past(wr_en_i)); // R11

endmodule

// File: rtl/tlbri_engine.sv
module tlbri_engine
  import tlbri_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VMID_W = 16,
  parameter int OP_W   = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [VMID_W-1:0] cur_vmid_i,
  input  logic              cur_secure_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              unpred_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic              fill_valid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              fill_ns_i,
  input  logic [1:0]        fill_gran_i,
  input  logic [1:0]        fill_lvl_i,
  input  logic [IPA_W-1:0]  fill_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [VMID_W-1:0] rd_vmid_o,
  output logic              rd_ns_o,
  output logic [1:0]        rd_gran_o,
  output logic [1:0]        rd_lvl_o,
  output logic [IPA_W-1:0]  rd_addr_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  range_cmd_t        dec_cmd;
  logic              dec_unpred;
  range_cmd_t        cmd_q;
  logic [VMID_W-1:0] vmid_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              ready_q;
  logic              done_q;
  logic              unpred_q;
  logic              accept;
  logic              hit;
  logic              clr_en;

  logic              s_valid;
  logic [VMID_W-1:0] s_vmid;
  logic              s_ns;
  logic [1:0]        s_gran;
  logic [1:0]        s_lvl;
  logic [IPA_W-1:0]  s_addr;

  tlbri_decode #(.OP_W(OP_W)) u_decode (
    .op_i     (op_i),
    .secure_i (cur_secure_i),
    .cmd_o    (dec_cmd),
    .unpred_o (dec_unpred)
  );

  assign accept = req_i && ready_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= 1'b0;
      ready_q  <= 1'b1;
      done_q   <= 1'b0;
      unpred_q <= 1'b0;
      idx_q    <= '0;
      cmd_q    <= '0;
      vmid_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        cmd_q    <= dec_cmd;
        unpred_q <= dec_unpred;
        vmid_q   <= cur_vmid_i;
        busy_q   <= 1'b1;
        ready_q  <= 1'b0;
        idx_q    <= '0;
      end else if (busy_q) begin
        if (idx_q == LAST_IDX) begin
          busy_q  <= 1'b0;
          ready_q <= 1'b1;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  tlbri_store #(.DEPTH(DEPTH), .VMID_W(VMID_W)) u_store (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .wr_en_i      (fill_en_i),
    .wr_idx_i     (fill_idx_i),
    .wr_valid_i   (fill_valid_i),
    .wr_vmid_i    (fill_vmid_i),
    .wr_ns_i      (fill_ns_i),
    .wr_gran_i    (fill_gran_i),
    .wr_lvl_i     (fill_lvl_i),
    .wr_addr_i    (fill_addr_i),
    .clr_en_i     (clr_en),
    .clr_idx_i    (idx_q),
    .scan_idx_i   (idx_q),
    .scan_valid_o (s_valid),
    .scan_vmid_o  (s_vmid),
    .scan_ns_o    (s_ns),
    .scan_gran_o  (s_gran),
    .scan_lvl_o   (s_lvl),
    .scan_addr_o  (s_addr),
    .rd_idx_i     (rd_idx_i),
    .rd_valid_o   (rd_valid_o),
    .rd_vmid_o    (rd_vmid_o),
    .rd_ns_o      (rd_ns_o),
    .rd_gran_o    (rd_gran_o),
    .rd_lvl_o     (rd_lvl_o),
    .rd_addr_o    (rd_addr_o)
  );

  tlbri_match #(.VMID_W(VMID_W)) u_match (
    .cmd_i     (cmd_q),
    .vmid_i    (vmid_q),
    .e_valid_i (s_valid),
    .e_vmid_i  (s_vmid),
    .e_ns_i    (s_ns),
    .e_gran_i  (s_gran),
    .e_lvl_i   (s_lvl),
    .e_addr_i  (s_addr),
    .hit_o     (hit)
  );

  assign clr_en   = busy_q && hit;
  assign ready_o  = ready_q;
  assign done_o   = done_q;
  assign unpred_o = unpred_q;

  AST_READY_LOW_IN_SCAN: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |-> !ready_o); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> ($past(busy_q) && $past(idx_q) == LAST_IDX)); // R9

  AST_RSVD_GRAN_NO_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && cmd_q.gran == GR_RSVD) |-> !clr_en); // R2

  AST_UNPRED_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_q |=> $stable(unpred_o)); // R8

endmodule

// File: tb/sim_tlbri_engine.sv
`timescale 1ns/1ps
module sim_tlbri_engine;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [63:0] op = '0;
  logic [15:0] cur_vmid = '0;
  logic        cur_sec = 1'b0;
  logic        ready, done, unpred;
  logic        f_en = 1'b0;
  logic [3:0]  f_idx = '0;
  logic        f_valid = 1'b0;
  logic [15:0] f_vmid = '0;
  logic        f_ns = 1'b0;
  logic [1:0]  f_gran = '0;
  logic [1:0]  f_lvl = '0;
  logic [52:0] f_addr = '0;
  logic [3:0]  rd_idx = '0;
  logic        rd_valid, rd_ns;
  logic [15:0] rd_vmid;
  logic [1:0]  rd_gran, rd_lvl;
  logic [52:0] rd_addr;

  always #10 clk = ~clk;

  tlbri_engine u0 (
    .clk_i(clk), .rst_i(rst), .req_i(req), .op_i(op), .cur_vmid_i(cur_vmid),
    .cur_secure_i(cur_sec), .ready_o(ready), .done_o(done), .unpred_o(unpred),
    .fill_en_i(f_en), .fill_idx_i(f_idx), .fill_valid_i(f_valid), .fill_vmid_i(f_vmid),
    .fill_ns_i(f_ns), .fill_gran_i(f_gran), .fill_lvl_i(f_lvl), .fill_addr_i(f_addr),
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_vmid_o(rd_vmid), .rd_ns_o(rd_ns),
    .rd_gran_o(rd_gran), .rd_lvl_o(rd_lvl), .rd_addr_o(rd_addr)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  bit          m_v  [DEPTH];
  logic [15:0] m_vm [DEPTH];
  bit          m_ns [DEPTH];
  logic [1:0]  m_g  [DEPTH];
  logic [1:0]  m_l  [DEPTH];
  logic [52:0] m_a  [DEPTH];

  bit    done_exp_q[$];
  string done_tag_q[$];
  bit    rd_exp_q[$];
  string rd_tag_q[$];
  logic  rd_stb = 1'b0;
  logic  rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_stb;

  task automatic chk(input bit ok, input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // monitor: compares results as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (done_exp_q.size() == 0) chk(1'b0, "R9 spurious done", 64'(done), 64'd0);
        else begin
          bit e;
          string t;
          e = done_exp_q.pop_front();
          t = done_tag_q.pop_front();
          chk(unpred == e, t, 64'(unpred), 64'(e));
        end
      end
      if (rd_pend && rd_exp_q.size() != 0) begin
        bit e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        chk(rd_valid == e, t, 64'(rd_valid), 64'(e));
      end
    end
  end

  function automatic logic [63:0] mk(input bit ns, input logic [1:0] tg, input logic [1:0] sc,
                                     input logic [4:0] num, input logic [1:0] ttl,
                                     input logic [36:0] base, input logic [14:0] rsv);
    return {ns, rsv, tg, sc, num, ttl, base};
  endfunction

  function automatic int gsh(input logic [1:0] g);
    return (g == 2'b01) ? 12 : (g == 2'b10) ? 14 : 16;
  endfunction

  function automatic bit exp_hit(input int i, input logic [63:0] o, input logic [15:0] vm, input bit sec);
    logic [1:0]  g;
    logic [1:0]  h;
    logic [63:0] base;
    logic [63:0] span;
    logic [63:0] a;
    bit          nst;
    int          sc;
    g = o[47:46];
    if (g == 2'b00) return 1'b0;
    sc   = int'(o[45:44]);
    base = {27'b0, o[36:0]} << gsh(g);
    span = (64'(o[43:39]) + 64'd1) << (5 * sc + 1 + gsh(g));
    h = o[38:37];
    if (g == 2'b10 && h == 2'b01) h = 2'b00;
    nst = sec ? o[63] : 1'b1;
    a = {11'b0, m_a[i]};
    return m_v[i] && (m_vm[i] == vm) && (m_ns[i] == nst) && (m_g[i] == g) &&
           (h == 2'b00 || m_l[i] == h) && (a >= base) && (a < base + span);
  endfunction

  function automatic bit exp_unpred(input logic [63:0] o);
    logic [1:0]  g;
    logic [1:0]  h;
    logic [63:0] a;
    g = o[47:46];
    h = o[38:37];
    if (g == 2'b00) return 1'b0;
    a = {27'b0, o[36:0]} << gsh(g);
    if (g == 2'b01 && h == 2'b01) return |a[29:12];
    if (g == 2'b01 && h == 2'b10) return |a[20:12];
    if (g == 2'b10 && h == 2'b10) return |a[24:14];
    if (g == 2'b11 && h == 2'b01) return |a[41:16];
    if (g == 2'b11 && h == 2'b10) return |a[28:16];
    return 1'b0;
  endfunction

  task automatic fill(input int i, input bit v, input logic [15:0] vm, input bit ns,
                      input logic [1:0] g, input logic [1:0] l, input logic [52:0] a);
    @(negedge clk);
    f_en = 1'b1; f_idx = 4'(i); f_valid = v; f_vmid = vm; f_ns = ns;
    f_gran = g; f_lvl = l; f_addr = a;
    @(negedge clk);
    f_en = 1'b0;
    m_v[i] = v; m_vm[i] = vm; m_ns[i] = ns; m_g[i] = g; m_l[i] = l; m_a[i] = a;
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      rd_stb = 1'b1;
      rd_exp_q.push_back(m_v[i]);
      rd_tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  // driver: pushes expectations, then runs one invalidate
  task automatic do_op(input logic [63:0] o, input logic [15:0] vm, input bit sec, input string tag,
                       input int col = -1, input logic [52:0] col_addr = '0,
                       input bit hold = 1'b0, input logic [63:0] hold_op = '0);
    bit hits [DEPTH];
    int n;
    for (int i = 0; i < DEPTH; i++) hits[i] = exp_hit(i, o, vm, sec);
    done_exp_q.push_back(exp_unpred(o));
    done_tag_q.push_back({tag, " unpred R8"});
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; op = o; cur_vmid = vm; cur_sec = sec;
    @(posedge clk);
    @(negedge clk);
    if (hold) op = hold_op;
    else      req = 1'b0;
    n = 0;
    if (col == 0) begin
      f_en = 1'b1; f_idx = 4'(col); f_valid = 1'b1; f_vmid = vm;
      f_ns = sec ? o[63] : 1'b1; f_gran = o[47:46]; f_lvl = 2'b11; f_addr = col_addr;
    end
    while (!done && n < DEPTH + 4) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      f_en = 1'b0;
      if (hold && n == 10) req = 1'b0;
      if (n == 3) chk(ready == 1'b0, "R9 ready low in scan", 64'(ready), 64'd0);
      if (col > 0 && n == col) begin
        f_en = 1'b1; f_idx = 4'(col); f_valid = 1'b1; f_vmid = vm;
        f_ns = sec ? o[63] : 1'b1; f_gran = o[47:46]; f_lvl = 2'b11; f_addr = col_addr;
      end
    end
    chk(n == DEPTH, "R9 done latency", 64'(n), 64'(DEPTH));
    for (int i = 0; i < DEPTH; i++) if (hits[i]) m_v[i] = 1'b0;
    if (col >= 0) begin
      m_v[col] = 1'b1; m_vm[col] = vm; m_ns[col] = sec ? o[63] : 1'b1;
      m_g[col] = o[47:46]; m_l[col] = 2'b11; m_a[col] = col_addr;
    end
    readback(tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_vm[i] = '0; m_ns[i] = 1'b0; m_g[i] = '0; m_l[i] = '0; m_a[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R9 reset ready", 64'(ready), 64'd1);
    chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
    readback("R11 reset state");

    fill(0, 1, 16'd5, 1, 2'b01, 2'b11, 53'h100000);
    fill(1, 1, 16'd5, 1, 2'b01, 2'b11, 53'h103000);
    fill(2, 1, 16'd5, 1, 2'b01, 2'b11, 53'h104000);
    fill(3, 1, 16'd5, 1, 2'b01, 2'b11, 53'h0FF000);
    fill(4, 1, 16'd5, 1, 2'b10, 2'b11, 53'h100000);
    fill(5, 1, 16'd6, 1, 2'b01, 2'b11, 53'h101000);
    fill(6, 1, 16'd5, 0, 2'b01, 2'b11, 53'h102000);
    fill(7, 1, 16'd5, 1, 2'b01, 2'b10, 53'h102000);
    // R1 R3 R4 R6 R7: reserved bits set, space bit 0 ignored from non-secure state
    do_op(mk(0, 2'b01, 2'd0, 5'd1, 2'b00, 37'h100, 15'h7ABC), 16'd5, 1'b0, "R1 R3 R4 R6 R7 4K window");
    // R7: secure request with space bit 0 reaches the secure entry
    do_op(mk(0, 2'b01, 2'd0, 5'd1, 2'b00, 37'h100, 15'h0), 16'd5, 1'b1, "R7 secure space");

    fill(8, 1, 16'd5, 1, 2'b10, 2'b10, 53'h800000);
    fill(9, 1, 16'd5, 1, 2'b10, 2'b11, 53'h804000);
    // R5: 16K with hint 01 acts as any level
    do_op(mk(1, 2'b10, 2'd1, 5'd0, 2'b01, 37'h200, 15'h0), 16'd5, 1'b0, "R5 16K hint01 any");

    fill(10, 1, 16'd5, 1, 2'b11, 2'b10, 53'h10000000);
    fill(11, 1, 16'd5, 1, 2'b11, 2'b11, 53'h10010000);
    do_op(mk(1, 2'b11, 2'd0, 5'd3, 2'b11, 37'h1000, 15'h0), 16'd5, 1'b0, "R5 64K level3 only");

    // R2: reserved granule clears nothing
    do_op(mk(1, 2'b00, 2'd0, 5'd1, 2'b00, 37'h104, 15'h0), 16'd5, 1'b0, "R2 reserved granule");

    // R8 misalignment flags
    do_op(mk(1, 2'b01, 2'd0, 5'd1, 2'b01, 37'h1, 15'h0), 16'd5, 1'b0, "R8 4K hint01 misaligned");
    do_op(mk(1, 2'b11, 2'd0, 5'd0, 2'b10, 37'h1, 15'h0), 16'd5, 1'b0, "R8 64K hint10 misaligned");
    do_op(mk(1, 2'b11, 2'd0, 5'd0, 2'b10, 37'h2000, 15'h0), 16'd5, 1'b0, "R8 64K hint10 aligned");
    do_op(mk(1, 2'b10, 2'd0, 5'd0, 2'b10, 37'h1, 15'h0), 16'd5, 1'b0, "R8 16K hint10 misaligned");
    fill(12, 1, 16'd5, 1, 2'b01, 2'b01, 53'h40000000);
    do_op(mk(1, 2'b01, 2'd0, 5'd0, 2'b01, 37'h40000, 15'h0), 16'd5, 1'b0, "R5 R8 4K level1 aligned");

    // R4: window end above the 53-bit IPA space
    fill(13, 1, 16'd5, 1, 2'b11, 2'b11, 53'h1F_FFFF_FFFF_0000);
    fill(14, 1, 16'd5, 1, 2'b11, 2'b11, 53'h0);
    do_op(mk(1, 2'b11, 2'd3, 5'd31, 2'b00, 37'h1F_FFFF_FFFF, 15'h0), 16'd5, 1'b0, "R4 wide window no wrap");

    // R10: fill and clear meet on entry 1
    fill(0, 1, 16'd5, 1, 2'b01, 2'b11, 53'h100000);
    fill(1, 1, 16'd5, 1, 2'b01, 2'b11, 53'h103000);
    do_op(mk(1, 2'b01, 2'd0, 5'd1, 2'b00, 37'h100, 15'h0), 16'd5, 1'b0, "R10 fill vs clear", 1, 53'h101000);
    @(negedge clk);
    rd_idx = 4'd1;
    @(negedge clk);
    chk(rd_addr == 53'h101000, "R10 R11 filled address kept", 64'(rd_addr), 64'h101000);
    chk(rd_vmid == 16'd5, "R11 read vmid", 64'(rd_vmid), 64'd5);
    chk(rd_lvl == 2'b11, "R11 read level", 64'(rd_lvl), 64'd3);

    // R9: request held during scan is ignored
    fill(0, 1, 16'd5, 1, 2'b01, 2'b11, 53'h100000);
    do_op(mk(1, 2'b01, 2'd0, 5'd0, 2'b00, 37'h100, 15'h0), 16'd5, 1'b0, "R9 held request ignored",
          -1, '0, 1'b1, mk(1, 2'b01, 2'd0, 5'd0, 2'b00, 37'h104, 15'h0));
    repeat (20) @(negedge clk);
    readback("R9 no second sweep");

    chk(done_exp_q.size() == 0, "R9 all done pulses seen", 64'(done_exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule